// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out the state hand-over that happens when a processor core accepts an exception or an interrupt. The core raises a one-cycle request. With it the core presents its current program counter, the value of general register 15, the faulting virtual address, a 12-bit event code, an interrupt flag, a flag that the faulting instruction sits in a branch delay slot, and a flag that the core was asleep. On the next clock edge the block does several things at once:

- stores the corrected return address, the prior status word and the register-15 value in its shadow registers;
- raises the privilege, bank-select and block bits of the status word;
- records the cause code;
- updates the translation fault registers when the event is a translation fault;
- presents the handler address together with a one-cycle done pulse, so the core can fetch from that address.

The block owns the status word, the vector base, the two cause registers, the fault-address register and the page-table-entry-high register. Software writes to the status word, the vector base and the page-table-entry-high register go through plain write ports. A bank-swap pulse tells the register file to exchange r0 to r7 with their bank copies whenever the bank-select bit changes, whether by an entry or by a status write. A request that arrives while the block bit is already set cannot be handled safely, so the block converts it into a power-on reset entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `exc_req_i` is sampled high, the next cycle shows `entry_done_o` high for exactly one cycle. In that cycle `ssr_o` holds the status word from before the request, `sgr_o` holds the `r15_i` value, and `spc_o` holds the corrected return address (R7, R8, R9).
- R2: An entry sets status bits 30 (privileged), 29 (bank select) and 28 (block) and keeps every other bit, except as R4 states.
- R3: `handler_pc_o` is the vector base plus 0x600 for an interrupt, plus 0x400 for codes 0x040 and 0x060 (translation miss on load or store), and plus 0x100 for any other non-reset exception.
- R4: Codes 0x000 and 0x020, taken as exceptions, give `handler_pc_o` = 0xA0000000 and clear the vector base to 0. They also set status bits 7:4 to all ones and clear status bit 15.
- R5: Exception codes 0x040, 0x060, 0x080, 0x0A0 and 0x0C0 load `tea_o` with the fault address. They replace bits 31:10 of `pteh_o` with the same bits of the fault address and keep bits 9:0. Other events leave both registers unchanged.
- R6: An interrupt writes its code to `intevt_o` and leaves `expevt_o` alone. An exception writes its code to `expevt_o` and leaves `intevt_o` alone.
- R7: With `halted_i` high, the saved address is 2 bytes past `cur_pc_i`, and `halt_clear_o` pulses together with `entry_done_o`.
- R8: With `in_delay_slot_i` high, the saved address is reduced by 2 bytes so that the branch runs again.
- R9: For exception code 0x160 (trap), the saved address is advanced by 2 more bytes.
- R10: A request taken while status bit 28 is already set is handled as code 0x000 (R4). `expevt_o` becomes 0x000 and `intevt_o` is unchanged, even for an interrupt.
- R11: `bank_swap_o` pulses in the cycle after any update that changes status bit 29, and only then.
- R12: A request wins over status, vector-base and page-table-entry-high writes in the same cycle, and those writes are dropped. Without a request or a write, every register holds its value.
- R13: After reset the status word is 0x400000F0, `handler_pc_o` is 0xA0000000, all other registers are 0, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Accept an exception or interrupt this cycle |
| exc_is_irq_i | input | 1 | The request is an interrupt |
| exc_code_i | input | 12 | Event code |
| cur_pc_i | input | 32 | Address of the affected instruction |
| r15_i | input | 32 | Current value of general register 15 |
| fault_addr_i | input | 32 | Faulting virtual address |
| in_delay_slot_i | input | 1 | Affected instruction is in a delay slot |
| halted_i | input | 1 | Core was sleeping |
| sr_wr_en_i | input | 1 | Status word write enable |
| sr_wr_data_i | input | 32 | Status word write data |
| vbr_wr_en_i | input | 1 | Vector base write enable |
| vbr_wr_data_i | input | 32 | Vector base write data |
| pteh_wr_en_i | input | 1 | Page-table-entry-high write enable |
| pteh_wr_data_i | input | 32 | Page-table-entry-high write data |
| entry_done_o | output | 1 | One-cycle pulse: fetch from `handler_pc_o` |
| handler_pc_o | output | 32 | Handler address |
| halt_clear_o | output | 1 | Pulse: leave sleep state |
| bank_swap_o | output | 1 | Pulse: swap r0 to r7 with bank copies |
| sr_o | output | 32 | Status word |
| spc_o | output | 32 | Saved return address |
| ssr_o | output | 32 | Saved status word |
| sgr_o | output | 32 | Saved register 15 |
| vbr_o | output | 32 | Vector base |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt code |
| tea_o | output | 32 | Translation fault address |
| pteh_o | output | 32 | Page-table-entry-high |

## Verification
Each field is registered exactly once, at the accepting edge, so a wrong classification or a wrong address correction shows up at the ports in the very next cycle:
- a wrong class gives the wrong handler offset, or a cause code in the wrong register;
- a wrong correction gives a saved address that is off by two bytes.

A missed block-bit check shows up differently. The handler address is not the reset address and the vector base stays nonzero. A wrongly tracked bank bit shows up as a missing or extra swap pulse in that same cycle. The sweep covers every class against every combination of sleep, delay slot, block and bank bits, so each of these errors appears on at least one entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int XLEN  = 32;
    parameter int EVT_W = 12;

    // Status word bit positions
    localparam int SR_PRIV_BIT   = 30;
    localparam int SR_BANK_BIT   = 29;
    localparam int SR_BLOCK_BIT  = 28;
    localparam int SR_FPOFF_BIT  = 15;
    localparam int SR_MASK_LSB   = 4;
    localparam int SR_MASK_W     = 4;

    localparam int VPN_LSB       = 10;
    localparam int INSN_BYTES    = 2;

    localparam logic [EVT_W-1:0] EVT_POWER_ON   = EVT_W'(12'h000);
    localparam logic [EVT_W-1:0] EVT_MANUAL_RST = EVT_W'(12'h020);
    localparam logic [EVT_W-1:0] EVT_XLAT_FIRST = EVT_W'(12'h040);
    localparam logic [EVT_W-1:0] EVT_XLAT_STEP  = EVT_W'(12'h020);
    localparam logic [EVT_W-1:0] EVT_TRAP       = EVT_W'(12'h160);
    localparam int XLAT_EVT_N  = 5;   // five translation fault codes
    localparam int XLAT_MISS_N = 2;   // first two are misses

    localparam logic [XLEN-1:0] SR_RESET_VAL = XLEN'(32'h4000_00F0);

    typedef struct packed {
        logic             is_irq;
        logic             is_reset;
        logic             is_xlat_fault;
        logic             is_xlat_miss;
        logic             is_trap;
        logic [EVT_W-1:0] code;
    } evt_class_t;

    typedef struct packed {
        logic [XLEN-1:0]  sr;
        logic [XLEN-1:0]  spc;
        logic [XLEN-1:0]  ssr;
        logic [XLEN-1:0]  sgr;
        logic [XLEN-1:0]  vbr;
        logic [EVT_W-1:0] expevt;
        logic [EVT_W-1:0] intevt;
        logic [XLEN-1:0]  tea;
        logic [XLEN-1:0]  pteh;
        logic [XLEN-1:0]  pc;
        logic             done;
        logic             halt_clr;
        logic             swap;
    } ctx_t;
endpackage

// File: rtl/exc_event_decode.sv
module exc_event_decode
    import exc_entry_pkg::*;
#(
    parameter int FAULT_N = XLAT_EVT_N,
    parameter int MISS_N  = XLAT_MISS_N
) (
    input  logic [EVT_W-1:0] code_i,
    input  logic             irq_i,
    input  logic             blocked_i,
    output evt_class_t       cls_o
);
    localparam int MISS_W = (MISS_N < FAULT_N) ? MISS_N : FAULT_N;

    logic [FAULT_N-1:0] fault_hit;

    generate
        for (genvar g = 0; g < FAULT_N; g++) begin : g_fault
            assign fault_hit[g] =
                (code_i == EVT_W'(EVT_XLAT_FIRST + EVT_W'(g) * EVT_XLAT_STEP));
        end
    endgenerate

    logic plain_exc;

    always_comb begin
        plain_exc           = ~irq_i & ~blocked_i;
        cls_o.is_irq        = irq_i & ~blocked_i;
        cls_o.code          = blocked_i ? EVT_POWER_ON : code_i;
        cls_o.is_reset      = blocked_i |
                              (plain_exc & ((code_i == EVT_POWER_ON) |
                                            (code_i == EVT_MANUAL_RST)));
        cls_o.is_xlat_fault = plain_exc & (|fault_hit);
        cls_o.is_xlat_miss  = plain_exc & (|fault_hit[MISS_W-1:0]);
        cls_o.is_trap       = plain_exc & (code_i == EVT_TRAP);
    end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000),
    parameter int              OFS_GEN  = 'h100,
    parameter int              OFS_MISS = 'h400,
    parameter int              OFS_IRQ  = 'h600
) (
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic            halted_i,
    input  logic            in_slot_i,
    input  evt_class_t      cls_i,
    input  logic [XLEN-1:0] vbr_i,
    output logic [XLEN-1:0] saved_pc_o,
    output logic [XLEN-1:0] handler_pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] wake_pc;
    logic [XLEN-1:0] slot_pc;

    always_comb begin
        wake_pc    = halted_i  ? cur_pc_i + STEP : cur_pc_i;
        slot_pc    = in_slot_i ? wake_pc - STEP  : wake_pc;
        saved_pc_o = cls_i.is_trap ? slot_pc + STEP : slot_pc;

        if (cls_i.is_reset)
            handler_pc_o = RESET_PC;
        else if (cls_i.is_irq)
            handler_pc_o = vbr_i + XLEN'(OFS_IRQ);
        else if (cls_i.is_xlat_miss)
            handler_pc_o = vbr_i + XLEN'(OFS_MISS);
        else
            handler_pc_o = vbr_i + XLEN'(OFS_GEN);
    end
endmodule

// File: rtl/exc_sr_next.sv
module exc_sr_next
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] sr_i,
    input  logic            entry_i,
    input  logic            reset_evt_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] sr_o,
    output logic            swap_o
);
    always_comb begin
        sr_o = sr_i;
        if (entry_i) begin
            sr_o[SR_PRIV_BIT]  = 1'b1;
            sr_o[SR_BANK_BIT]  = 1'b1;
            sr_o[SR_BLOCK_BIT] = 1'b1;
            if (reset_evt_i) begin
                sr_o[SR_MASK_LSB +: SR_MASK_W] = '1;
                sr_o[SR_FPOFF_BIT]             = 1'b0;
            end
        end else if (wr_en_i) begin
            sr_o = wr_data_i;
        end
        swap_o = sr_o[SR_BANK_BIT] ^ sr_i[SR_BANK_BIT];
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             exc_req_i,
    input  logic             exc_is_irq_i,
    input  logic [EVT_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]  cur_pc_i,
    input  logic [XLEN-1:0]  r15_i,
    input  logic [XLEN-1:0]  fault_addr_i,
    input  logic             in_delay_slot_i,
    input  logic             halted_i,
    input  logic             sr_wr_en_i,
    input  logic [XLEN-1:0]  sr_wr_data_i,
    input  logic             vbr_wr_en_i,
    input  logic [XLEN-1:0]  vbr_wr_data_i,
    input  logic             pteh_wr_en_i,
    input  logic [XLEN-1:0]  pteh_wr_data_i,
    output logic             entry_done_o,
    output logic [XLEN-1:0]  handler_pc_o,
    output logic             halt_clear_o,
    output logic             bank_swap_o,
    output logic [XLEN-1:0]  sr_o,
    output logic [XLEN-1:0]  spc_o,
    output logic [XLEN-1:0]  ssr_o,
    output logic [XLEN-1:0]  sgr_o,
    output logic [XLEN-1:0]  vbr_o,
    output logic [EVT_W-1:0] expevt_o,
    output logic [EVT_W-1:0] intevt_o,
    output logic [XLEN-1:0]  tea_o,
    output logic [XLEN-1:0]  pteh_o
);
    localparam logic [XLEN-1:0] VPN_MASK = ~((XLEN'(1) << VPN_LSB) - XLEN'(1));

    ctx_t            ctx_d, ctx_q;
    evt_class_t      cls;
    logic [XLEN-1:0] saved_pc;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] sr_nx;
    logic            swap_nx;

    exc_event_decode u_decode (
        .code_i    (exc_code_i),
        .irq_i     (exc_is_irq_i),
        .blocked_i (ctx_q.sr[SR_BLOCK_BIT]),
        .cls_o     (cls)
    );

    exc_vector_calc #(.RESET_PC(RESET_PC)) u_vector (
        .cur_pc_i     (cur_pc_i),
        .halted_i     (halted_i),
        .in_slot_i    (in_delay_slot_i),
        .cls_i        (cls),
        .vbr_i        (ctx_q.vbr),
        .saved_pc_o   (saved_pc),
        .handler_pc_o (vec_pc)
    );

    exc_sr_next u_sr (
        .sr_i        (ctx_q.sr),
        .entry_i     (exc_req_i),
        .reset_evt_i (cls.is_reset),
        .wr_en_i     (sr_wr_en_i),
        .wr_data_i   (sr_wr_data_i),
        .sr_o        (sr_nx),
        .swap_o      (swap_nx)
    );

    always_comb begin
        ctx_d          = ctx_q;
        ctx_d.done     = 1'b0;
        ctx_d.halt_clr = 1'b0;
        ctx_d.sr       = sr_nx;
        ctx_d.swap     = swap_nx;

        if (exc_req_i) begin
            ctx_d.done     = 1'b1;
            ctx_d.halt_clr = halted_i;
            ctx_d.spc      = saved_pc;
            ctx_d.ssr      = ctx_q.sr;
            ctx_d.sgr      = r15_i;
            ctx_d.pc       = vec_pc;
            if (cls.is_irq)
                ctx_d.intevt = cls.code;
            else
                ctx_d.expevt = cls.code;
            if (cls.is_reset)
                ctx_d.vbr = '0;
            if (cls.is_xlat_fault) begin
                ctx_d.tea  = fault_addr_i;
                ctx_d.pteh = (ctx_q.pteh & ~VPN_MASK) | (fault_addr_i & VPN_MASK);
            end
        end else begin
            if (vbr_wr_en_i)
                ctx_d.vbr = vbr_wr_data_i;
            if (pteh_wr_en_i)
                ctx_d.pteh = pteh_wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctx_q    <= '0;
            ctx_q.sr <= SR_RESET_VAL;
            ctx_q.pc <= RESET_PC;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign entry_done_o = ctx_q.done;
    assign handler_pc_o = ctx_q.pc;
    assign halt_clear_o = ctx_q.halt_clr;
    assign bank_swap_o  = ctx_q.swap;
    assign sr_o         = ctx_q.sr;
    assign spc_o        = ctx_q.spc;
    assign ssr_o        = ctx_q.ssr;
    assign sgr_o        = ctx_q.sgr;
    assign vbr_o        = ctx_q.vbr;
    assign expevt_o     = ctx_q.expevt;
    assign intevt_o     = ctx_q.intevt;
    assign tea_o        = ctx_q.tea;
    assign pteh_o       = ctx_q.pteh;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            exc_req_i,
    input logic [XLEN-1:0] r15_i,
    input logic            entry_done_o,
    input logic [XLEN-1:0] handler_pc_o,
    input logic            halt_clear_o,
    input logic            bank_swap_o,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] spc_o,
    input logic [XLEN-1:0] ssr_o,
    input logic [XLEN-1:0] sgr_o,
    input logic [XLEN-1:0] vbr_o
);
    // R1
    done_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_done_o |-> $past(exc_req_i));
    // R1
    sgr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_done_o |-> sgr_o == $past(r15_i));
    // R1
    ssr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_done_o |-> ssr_o == $past(sr_o));
    // R2
    sr_entry_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_done_o |-> (sr_o[SR_PRIV_BIT] && sr_o[SR_BANK_BIT] && sr_o[SR_BLOCK_BIT]));
    // R10
    blocked_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_done_o && $past(sr_o[SR_BLOCK_BIT])) |-> (handler_pc_o == RESET_PC && vbr_o == '0));
    // R11
    bank_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sr_o[SR_BANK_BIT] != $past(sr_o[SR_BANK_BIT])) |-> bank_swap_o);
    // R12
    spc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(exc_req_i) |-> $stable(spc_o));
    // R7
    halt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_clear_o |-> entry_done_o);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.RESET_PC(RESET_PC)) chk_i (.*);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, irq = 1'b0, slot = 1'b0, halted = 1'b0;
    logic [11:0] code = '0;
    logic [31:0] pc = '0, r15 = '0, faddr = '0;
    logic        sr_we = 1'b0, vbr_we = 1'b0, pteh_we = 1'b0;
    logic [31:0] sr_wd = '0, vbr_wd = '0, pteh_wd = '0;

    logic        done, hclr, swap;
    logic [31:0] hpc, sr, spc, ssr, sgr, vbr, tea, pteh;
    logic [11:0] expevt, intevt;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_is_irq_i(irq),
        .exc_code_i(code), .cur_pc_i(pc), .r15_i(r15), .fault_addr_i(faddr),
        .in_delay_slot_i(slot), .halted_i(halted),
        .sr_wr_en_i(sr_we), .sr_wr_data_i(sr_wd),
        .vbr_wr_en_i(vbr_we), .vbr_wr_data_i(vbr_wd),
        .pteh_wr_en_i(pteh_we), .pteh_wr_data_i(pteh_wd),
        .entry_done_o(done), .handler_pc_o(hpc), .halt_clear_o(hclr),
        .bank_swap_o(swap), .sr_o(sr), .spc_o(spc), .ssr_o(ssr), .sgr_o(sgr),
        .vbr_o(vbr), .expevt_o(expevt), .intevt_o(intevt), .tea_o(tea), .pteh_o(pteh)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [11:0] code_of(input int c);
        case (c)
            0: return 12'h000;  1: return 12'h020;  2: return 12'h040;
            3: return 12'h060;  4: return 12'h080;  5: return 12'h0A0;
            6: return 12'h0C0;  7: return 12'h160;  8: return 12'h800;
            9: return 12'h1E0;  10: return 12'h400; default: return 12'h5A0;
        endcase
    endfunction

    logic [11:0] m_exp = '0, m_int = '0;
    logic [31:0] m_tea = '0;

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int idx;
        idx = 0;
        repeat (3) tick();
        // R13 reset state
        chk("R13 sr", sr, 32'h4000_00F0);
        chk("R13 pc", hpc, 32'hA000_0000);
        chk("R13 vbr", vbr, 0);
        chk("R13 spc", spc, 0);
        chk("R13 done", {31'b0, done}, 0);
        rst_n = 1'b1;
        tick();
        chk("R13 done after release", {31'b0, done}, 0);

        for (int c = 0; c < 12; c++)
        for (int h = 0; h < 2; h++)
        for (int d = 0; d < 2; d++)
        for (int bl = 0; bl < 2; bl++)
        for (int rb = 0; rb < 2; rb++) begin
            logic [31:0] sr0, vb, pt0, e_spc, e_sr, e_pc, e_vbr, e_pteh, adj;
            logic is_irq, blk, rst_e, tlb, miss, trap;
            logic [11:0] cd;
            idx++;
            cd = code_of(c);
            is_irq = (c >= 10);
            sr0 = 32'h0000_8030 | (32'(bl) << 28) | (32'(rb) << 29);
            vb = 32'h8C00_0000 + (32'(idx) << 8);
            pt0 = 32'hAAAA_A800 ^ 32'(idx * 5);
            sr_we = 1; sr_wd = sr0; vbr_we = 1; vbr_wd = vb; pteh_we = 1; pteh_wd = pt0;
            tick();
            sr_we = 0; vbr_we = 0; pteh_we = 0;
            req = 1; irq = is_irq; code = cd; halted = h[0]; slot = d[0];
            pc = 32'h0C00_1000 + 32'(idx * 16);
            r15 = 32'h0CFF_0000 - 32'(idx * 4);
            faddr = 32'h7654_3000 ^ (32'(idx) * 32'h0001_1357);
            tick();
            req = 0;
            // model
            blk = bl[0];
            rst_e = blk || (!is_irq && (cd == 12'h000 || cd == 12'h020));
            tlb = !blk && !is_irq && (cd >= 12'h040 && cd <= 12'h0C0);
            miss = !blk && !is_irq && (cd == 12'h040 || cd == 12'h060);
            trap = !blk && !is_irq && (cd == 12'h160);
            adj = pc + (h ? 2 : 0) - (d ? 2 : 0);
            e_spc = adj + (trap ? 2 : 0);
            e_sr = sr0 | 32'h7000_0000;
            if (rst_e) e_sr = (e_sr | 32'h0000_00F0) & ~32'h0000_8000;
            e_pc = rst_e ? 32'hA000_0000 : is_irq && !blk ? vb + 32'h600 :
                   miss ? vb + 32'h400 : vb + 32'h100;
            e_vbr = rst_e ? 32'h0 : vb;
            if (is_irq && !blk) m_int = cd; else m_exp = blk ? 12'h000 : cd;
            e_pteh = pt0;
            if (tlb) begin
                m_tea = faddr;
                e_pteh = (faddr & 32'hFFFF_FC00) | (pt0 & 32'h3FF);
            end
            chk("R1 done", {31'b0, done}, 1);
            chk("R1 ssr", ssr, sr0);
            chk("R1 sgr", sgr, r15);
            chk("R1 R7 R8 R9 spc", spc, e_spc);
            chk("R2 R4 sr", sr, e_sr);
            chk(blk ? "R10 pc" : "R3 R4 pc", hpc, e_pc);
            chk("R4 vbr", vbr, e_vbr);
            chk("R6 R10 expevt", {20'b0, expevt}, {20'b0, m_exp});
            chk("R6 intevt", {20'b0, intevt}, {20'b0, m_int});
            chk("R5 tea", tea, m_tea);
            chk("R5 pteh", pteh, e_pteh);
            chk("R7 halt_clear", {31'b0, hclr}, 32'(h));
            chk("R11 swap on entry", {31'b0, swap}, 32'(!rb[0]));
            tick();
            chk("R1 done single", {31'b0, done}, 0);
        end

        // R11: SR writes toggling and keeping the bank bit (currently set)
        sr_we = 1; sr_wd = 32'h0000_0010; tick(); sr_we = 0;
        chk("R11 swap on clear", {31'b0, swap}, 1);
        chk("R11 sr written", sr, 32'h0000_0010);
        sr_we = 1; sr_wd = 32'h0000_0020; tick(); sr_we = 0;
        chk("R11 no swap same bank", {31'b0, swap}, 0);

        // R12: idle holds state
        begin
            logic [31:0] s_spc, s_sr, s_vbr;
            s_spc = spc; s_sr = sr; s_vbr = vbr;
            repeat (4) tick();
            chk("R12 idle spc", spc, s_spc);
            chk("R12 idle sr", sr, s_sr);
            chk("R12 idle vbr", vbr, s_vbr);
            chk("R12 idle done", {31'b0, done}, 0);
            // R12: request wins over same-cycle writes
            req = 1; irq = 0; code = 12'h800; halted = 0; slot = 0; pc = 32'h0000_2000;
            sr_we = 1; sr_wd = 32'h0000_00FF; vbr_we = 1; vbr_wd = 32'h1234_0000;
            tick();
            req = 0; sr_we = 0; vbr_we = 0;
            chk("R12 ssr ignores write", ssr, s_sr);
            chk("R12 vbr write dropped", vbr, s_vbr);
            chk("R12 pc from old vbr", hpc, s_vbr + 32'h100);
            chk("R12 sr from old", sr, s_sr | 32'h7000_0000);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule